// File: doc/BRIEF.md
# Subroutine Call and Return Frame Sequencer

This block carries out the stack traffic of a subroutine call or return over several cycles. It owns the stack pointer (SP), the frame pointer (FP) and the program counter value that results from a call or return. A decode stage starts an operation with a one-cycle strobe and an operation code. It also supplies the current PC and a target value. For an absolute call the target is the 32-bit immediate. For a register call it is the contents of the named register.

A call reserves an eight-byte area below SP. That area holds the return address and one spare slot for the static chain. The call then pushes the caller's FP, points FP at the new stack top and jumps to the target. A return reverses this. SP is reset to FP, the saved FP is popped, the return address is popped into the PC, and SP then skips the spare slot.

All memory accesses go through a single-word port with a request/ready handshake. A `done_o` pulse marks the cycle in which the final PC, SP and FP are visible.

Top module: `frame_seq`

## Requirements
- R1: After reset, SP and FP both equal the STACK_TOP parameter with its two low bits cleared, the PC output equals RESET_PC, and busy_o, done_o and mem_req_o are low.
- R2: The operation code op_i is decoded as follows: 0 is an absolute call, 1 is a register call, 2 is a return, and 3 is a no-op. A start with code 3 produces no memory request, no busy, no done and no change to PC, SP or FP.
- R3: The first access of a call writes the return address to SP-8. The return address is PC+6 for code 0 and PC+2 for code 1. When this access is accepted, SP becomes SP-8.
- R4: The second access of a call writes the caller's FP to the address 4 below the current SP, and SP moves to that address. At completion, FP equals that new SP, which is the entry SP minus 12. The PC output equals the target captured at start.
- R5: At its start, a return copies FP into SP. Its first access reads the word at that address. The read word, with its two low bits cleared, becomes FP, and SP rises by 4.
- R6: The second access of a return reads the word at the current SP into the PC. SP then rises by 8, so the final SP is the entry FP plus 12, which skips the spare slot.
- R7: While mem_req_o is high and mem_ready_i is low, the access holds its address, write enable and write data, and SP does not move. The sequencer advances only on a cycle with request and ready both high.
- R8: done_o is high for exactly one cycle, the cycle after the final access is accepted. In that cycle busy_o is already low, and PC, SP and FP show their final values.
- R9: busy_o is high from the cycle after an accepted start until done_o. A start strobe that arrives while busy_o is high is ignored.
- R10: Every address placed on mem_addr_o has its two low bits equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle operation strobe |
| op_i | input | 2 | Operation code (see R2) |
| pc_i | input | 32 | PC of the call instruction |
| target_i | input | 32 | Call target: immediate or register value |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Word-aligned byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with ready |
| mem_ready_i | input | 1 | Access completes this cycle |
| pc_o | output | 32 | PC after the last call or return |
| sp_o | output | 32 | Stack pointer |
| fp_o | output | 32 | Frame pointer |
| done_o | output | 1 | Completion pulse |
| busy_o | output | 1 | Sequence in progress |

## Verification
Suppose SP is off by one slot, or the stored return offset is wrong. The error shows up on mem_addr_o or mem_wdata_o at the first accepted write of the next call, which is one to two handshakes after start. It also shows up in sp_o and fp_o at done_o. A wrong state sequence would surface as a missing or doubled done_o pulse, or as a read where a write was due. A corrupted frame only becomes visible at the PC and FP produced by the matching return, possibly many operations later. For that reason the bench nests calls deeply and then unwinds them, comparing each return against its own shadow stack.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;
  localparam int unsigned XW = 32;
  localparam int unsigned WORD_BYTES = XW / 8;
  typedef logic [XW-1:0] word_t;

  typedef enum logic [1:0] {
    OP_CALL_IMM = 2'd0,
    OP_CALL_REG = 2'd1,
    OP_RETURN   = 2'd2,
    OP_NONE     = 2'd3
  } seq_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PUSH_RA, ST_PUSH_FP, ST_POP_FP, ST_POP_PC
  } seq_state_e;

  function automatic word_t word_align(word_t a);
    return {a[XW-1:2], 2'b00};
  endfunction

  function automatic word_t ret_addr(seq_op_e op, word_t pc,
                                     int unsigned imm_len, int unsigned reg_len);
    return (op == OP_CALL_IMM) ? pc + word_t'(imm_len) : pc + word_t'(reg_len);
  endfunction

  function automatic word_t below(word_t base, int unsigned bytes);
    return word_align(base - word_t'(bytes));
  endfunction

  function automatic word_t above(word_t base, int unsigned bytes);
    return word_align(base + word_t'(bytes));
  endfunction
endpackage

// File: rtl/frame_seq_ctrl.sv
module frame_seq_ctrl
  import frame_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  seq_op_e    op_i,
  input  logic       mem_ready_i,
  output seq_state_e state_o,
  output logic       accept_o,
  output logic       step_o,
  output logic       finish_o,
  output logic       done_o
);
  seq_state_e state_q, state_d;

  assign accept_o = (state_q == ST_IDLE) && start_i && (op_i != OP_NONE);
  assign step_o   = (state_q != ST_IDLE) && mem_ready_i;
  assign finish_o = step_o && ((state_q == ST_PUSH_FP) || (state_q == ST_POP_PC));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (accept_o) state_d = (op_i == OP_RETURN) ? ST_POP_FP : ST_PUSH_RA;
      ST_PUSH_RA: if (step_o)   state_d = ST_PUSH_FP;
      ST_PUSH_FP: if (step_o)   state_d = ST_IDLE;
      ST_POP_FP:  if (step_o)   state_d = ST_POP_PC;
      ST_POP_PC:  if (step_o)   state_d = ST_IDLE;
      default:                  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= finish_o;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/frame_seq_regs.sv
module frame_seq_regs
  import frame_seq_pkg::*;
#(
  parameter word_t       STACK_TOP = 32'h0000_1000,
  parameter word_t       RESET_PC  = 32'h0000_0000,
  parameter int unsigned IMM_LEN   = 6,
  parameter int unsigned REG_LEN   = 2,
  parameter int unsigned RSV_BYTES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  seq_state_e state_i,
  input  logic       accept_i,
  input  logic       step_i,
  input  seq_op_e    op_i,
  input  word_t      pc_i,
  input  word_t      target_i,
  input  word_t      rdata_i,
  output word_t      sp_o,
  output word_t      fp_o,
  output word_t      pc_o,
  output word_t      ra_o
);
  word_t sp_q, fp_q, pc_q, ra_q, tgt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q  <= word_align(STACK_TOP);
      fp_q  <= word_align(STACK_TOP);
      pc_q  <= RESET_PC;
      ra_q  <= '0;
      tgt_q <= '0;
    end else if (accept_i) begin
      ra_q  <= ret_addr(op_i, pc_i, IMM_LEN, REG_LEN);
      tgt_q <= target_i;
      if (op_i == OP_RETURN) sp_q <= fp_q;
    end else if (step_i) begin
      unique case (state_i)
        ST_PUSH_RA: sp_q <= below(sp_q, RSV_BYTES);
        ST_PUSH_FP: begin
          sp_q <= below(sp_q, WORD_BYTES);
          fp_q <= below(sp_q, WORD_BYTES);
          pc_q <= tgt_q;
        end
        ST_POP_FP: begin
          fp_q <= word_align(rdata_i);
          sp_q <= above(sp_q, WORD_BYTES);
        end
        ST_POP_PC: begin
          pc_q <= rdata_i;
          sp_q <= above(sp_q, RSV_BYTES);
        end
        default: ;
      endcase
    end
  end

  assign sp_o = sp_q;
  assign fp_o = fp_q;
  assign pc_o = pc_q;
  assign ra_o = ra_q;
endmodule

// File: rtl/frame_seq.sv
module frame_seq
  import frame_seq_pkg::*;
#(
  parameter logic [31:0] STACK_TOP = 32'h0000_1000,
  parameter logic [31:0] RESET_PC  = 32'h0000_0000,
  parameter int unsigned IMM_LEN   = 6,
  parameter int unsigned REG_LEN   = 2,
  parameter int unsigned RSV_BYTES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [1:0]  op_i,
  input  logic [31:0] pc_i,
  input  logic [31:0] target_i,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  input  logic [31:0] mem_rdata_i,
  input  logic        mem_ready_i,
  output logic [31:0] pc_o,
  output logic [31:0] sp_o,
  output logic [31:0] fp_o,
  output logic        done_o,
  output logic        busy_o
);
  seq_state_e state;
  seq_op_e    op;
  logic       accept, step, finish;
  word_t      sp, fp, ra;

  assign op = seq_op_e'(op_i);

  frame_seq_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op),
    .mem_ready_i(mem_ready_i), .state_o(state), .accept_o(accept),
    .step_o(step), .finish_o(finish), .done_o(done_o)
  );

  frame_seq_regs #(
    .STACK_TOP(STACK_TOP), .RESET_PC(RESET_PC), .IMM_LEN(IMM_LEN),
    .REG_LEN(REG_LEN), .RSV_BYTES(RSV_BYTES)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .state_i(state), .accept_i(accept),
    .step_i(step), .op_i(op), .pc_i(pc_i), .target_i(target_i),
    .rdata_i(mem_rdata_i), .sp_o(sp), .fp_o(fp), .pc_o(pc_o), .ra_o(ra)
  );

  always_comb begin
    mem_req_o   = (state != ST_IDLE);
    mem_we_o    = (state == ST_PUSH_RA) || (state == ST_PUSH_FP);
    mem_wdata_o = (state == ST_PUSH_RA) ? ra : fp;
    unique case (state)
      ST_PUSH_RA: mem_addr_o = below(sp, RSV_BYTES);
      ST_PUSH_FP: mem_addr_o = below(sp, WORD_BYTES);
      default:    mem_addr_o = word_align(sp);
    endcase
  end

  assign sp_o   = sp;
  assign fp_o   = fp;
  assign busy_o = (state != ST_IDLE);
endmodule

// File: rtl/frame_seq_checker.sv
module frame_seq_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic [31:0] mem_addr_o,
  input logic [31:0] mem_wdata_o,
  input logic        mem_ready_i,
  input logic [31:0] sp_o,
  input logic        done_o,
  input logic        busy_o
);
  assert_addr_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00));

  assert_req_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ready_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) &&
       $stable(mem_wdata_o) && $stable(sp_o)));

  assert_push_moves_sp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o && mem_ready_i) |=> (sp_o == $past(mem_addr_o)));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  assert_busy_from_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));
endmodule

bind frame_seq frame_seq_checker chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .mem_req_o(mem_req_o),
  .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
  .mem_ready_i(mem_ready_i), .sp_o(sp_o), .done_o(done_o), .busy_o(busy_o)
);

// File: tb/frame_seq_tb.sv
module frame_seq_tb_top;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] TOP        = 32'h0000_1000;
  localparam logic [31:0] RST_PC     = 32'h0000_0100;

  logic        clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic [1:0]  op_i = 2'd0;
  logic [31:0] pc_i = '0, target_i = '0, mem_rdata_i = '0;
  logic        mem_ready_i = 1'b0;
  logic        mem_req_o, mem_we_o, done_o, busy_o;
  logic [31:0] mem_addr_o, mem_wdata_o, pc_o, sp_o, fp_o;

  logic [31:0] mem [logic [31:0]];
  logic [31:0] shadow [logic [31:0]];
  logic [31:0] m_sp, m_fp, m_pc;
  int vectors = 0, misses = 0, depth = 0, cycles = 0;
  bit stall = 1'b0, saw_req = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_seq #(.STACK_TOP(TOP), .RESET_PC(RST_PC)) dut_i (.*);

  always @(posedge clk) begin
    cycles++;
    if (mem_req_o) saw_req = 1'b1;
    if (mem_req_o && mem_ready_i && mem_we_o) mem[mem_addr_o] = mem_wdata_o;
  end

  always @(negedge clk) begin
    mem_ready_i = mem_req_o && !stall && ($urandom_range(0, 3) != 0);
    mem_rdata_i = mem.exists(mem_addr_o) ? mem[mem_addr_o] : 32'h0;
  end

  function automatic logic [31:0] rd(logic [31:0] a);
    return shadow.exists(a) ? shadow[a] : 32'h0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    misses++;
    $display("FAIL watchdog: actual hung expected progress");
    finish_run();
  end

  task automatic wait_done();
    int n = 0;
    @(negedge clk);
    while (!done_o) begin
      @(negedge clk);
      n++;
      if (n > 200) begin
        check("R8 done timeout", 32'd0, 32'd1);
        return;
      end
    end
  endtask

  task automatic run_op(logic [1:0] op, logic [31:0] pc, logic [31:0] tgt, bit poke);
    logic [31:0] ra, s0;
    @(negedge clk);
    start_i = 1'b1; op_i = op; pc_i = pc; target_i = tgt;
    @(negedge clk);
    if (poke) begin
      check("R9 busy after start", {31'd0, busy_o}, 32'd1);
      op_i = (op == 2'd2) ? 2'd0 : 2'd2;
      pc_i = ~pc;
      target_i = ~tgt;
      @(negedge clk);
    end
    start_i = 1'b0;
    // shadow model
    if (op == 2'd2) begin
      s0 = m_fp;
      m_fp = {rd(s0)[31:2], 2'b00};
      m_pc = rd(s0 + 4);
      m_sp = s0 + 12;
    end else begin
      ra = pc + ((op == 2'd0) ? 32'd6 : 32'd2);
      shadow[m_sp - 8] = ra;
      shadow[m_sp - 12] = m_fp;
      m_fp = m_sp - 12;
      m_sp = m_sp - 12;
      m_pc = tgt;
    end
    wait_done();
    check(op == 2'd2 ? "R6 return pc" : "R4 call pc", pc_o, m_pc);
    check(op == 2'd2 ? "R6 return sp" : "R4 call sp", sp_o, m_sp);
    check(op == 2'd2 ? "R5 return fp" : "R4 call fp", fp_o, m_fp);
    check("R8 busy low at done", {31'd0, busy_o}, 32'd0);
    if (op != 2'd2) begin
      check("R3 return address stored", mem.exists(m_sp + 4) ? mem[m_sp + 4] : 32'hx, ra);
      check("R4 caller fp stored", mem.exists(m_sp) ? mem[m_sp] : 32'hx, shadow[m_sp]);
    end
    @(negedge clk);
    check("R8 done single", {31'd0, done_o}, 32'd0);
  endtask

  initial begin
    logic [31:0] a0, s0;
    void'($urandom(32'd20240611));
    m_sp = TOP; m_fp = TOP; m_pc = RST_PC;
    repeat (3) @(negedge clk);
    check("R1 sp", sp_o, TOP);
    check("R1 fp", fp_o, TOP);
    check("R1 pc", pc_o, RST_PC);
    check("R1 busy/done/req", {29'd0, busy_o, done_o, mem_req_o}, 32'd0);
    rst_n = 1'b1;

    // R2: code 3 has no effect
    @(negedge clk);
    saw_req = 1'b0;
    start_i = 1'b1; op_i = 2'd3; pc_i = 32'h55; target_i = 32'hAA;
    @(negedge clk);
    start_i = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check("R2 no busy on code 3", {31'd0, busy_o | done_o}, 32'd0);
    end
    check("R2 no request on code 3", {31'd0, saw_req}, 32'd0);
    check("R2 state kept", sp_o ^ fp_o ^ pc_o, TOP ^ TOP ^ RST_PC);

    // directed calls of each kind, then unwind
    run_op(2'd0, 32'h0000_2000, 32'h0000_3000, 1'b0); depth++;
    run_op(2'd1, 32'h0000_3010, 32'h0000_4000, 1'b1); depth++;

    // R7: stalled access holds address and SP
    stall = 1'b1;
    @(negedge clk);
    start_i = 1'b1; op_i = 2'd0; pc_i = 32'h0000_4020; target_i = 32'h0000_5000;
    @(negedge clk);
    start_i = 1'b0;
    a0 = mem_addr_o; s0 = sp_o;
    repeat (4) @(negedge clk);
    check("R7 address held", mem_addr_o, a0);
    check("R7 sp held", sp_o, s0);
    check("R10 aligned", {30'd0, mem_addr_o[1:0]}, 32'd0);
    stall = 1'b0;
    shadow[m_sp - 8] = 32'h0000_4026;
    shadow[m_sp - 12] = m_fp;
    m_fp = m_sp - 12; m_sp = m_sp - 12; m_pc = 32'h0000_5000;
    wait_done(); depth++;
    check("R3 stall call pc", pc_o, m_pc);
    check("R3 stall call ra", mem[m_sp + 4], 32'h0000_4026);

    // R5: misaligned saved FP is aligned on pop
    mem[m_fp] = 32'h0000_0FF3;
    shadow[m_fp] = 32'h0000_0FF3;
    run_op(2'd2, 32'h0, 32'h0, 1'b1); depth--;
    check("R5 aligned fp", fp_o, 32'h0000_0FF0);
    // repair so later unwinding stays consistent
    m_fp = 32'h0000_0FF0;

    // constrained random mix
    for (int i = 0; i < 80; i++) begin
      logic [1:0] op;
      if (depth == 0 || (depth < 40 && $urandom_range(0, 2) != 0))
        op = $urandom_range(0, 1);
      else
        op = 2'd2;
      run_op(op, $urandom & 32'hFFFF_FFFE, $urandom & 32'hFFFF_FFFE,
             ($urandom_range(0, 3) == 0));
      if (op == 2'd2) depth--; else depth++;
    end
    finish_run();
  end
endmodule